// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block turns the system clock into the SCL waveform of an I2C master. Software supplies an 8-bit bit-rate value BR and a 2-bit prescaler select PS. One SCL period lasts 16 + 2·BR·4^PS system cycles. The period splits into a driven-low half and a released half, and each half lasts H = 8 + BR·4^PS cycles. The block does not drive SCL high. It asks the open-drain pad to pull the line low and otherwise releases it.

A slave may hold SCL low after the master lets go. The released half only starts counting once the sampled line is actually high, so a stretch lengthens the period by exactly the stretch time. BR and PS are captured once, at the start of each period. Two one-cycle strobes mark where SCL falls and where the high phase begins, and the data shifter uses them.

A combinational flag warns when the programmed divisor is below the number of system cycles per SCL period that the attached slaves need.

Top module: `scl_rate_gen`

## Requirements
- R1: During reset, and while `en` is low, `scl_drive_low`, `scl_rise` and `scl_fall` are all 0.
- R2: The driven-low phase of every period lasts exactly H = 8 + BR·4^PS cycles, where PS selects a multiplier of 1, 4, 16 or 64 (PS = 0..3).
- R3: When no slave holds the line, the distance from one `scl_fall` to the next is 2·H cycles, for every PS value.
- R4: If the line stays low for S cycles after the generator releases it, the released phase lasts H + S cycles. The period becomes 2·H + S.
- R5: `scl_fall` is high for one cycle, which is the first cycle of `scl_drive_low`. `scl_rise` is high for one cycle, which is the cycle after the line is first sampled high. Without a stretch, that is the second released cycle.
- R6: BR and PS are sampled only at the start of a period. A write made during a period, including during a stretch, changes neither phase of that period and takes effect in the next period.
- R7: If `en` drops, `scl_drive_low` is 0 from the next cycle on. When `en` rises again, a fresh driven-low phase begins one cycle later, marked by `scl_fall`.
- R8: `cfg_too_fast` is 1 exactly when 16 + 2·BR·4^PS is below the parameter `SLAVE_RATIO_MIN` (default 32).
- R9: `scl_rise` and `scl_fall` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Runs the generator; low releases SCL and clears the counters |
| bit_rate | input | 8 | Bit-rate value BR |
| prescale | input | 2 | Prescaler select PS (multiplier 4^PS) |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request for the pad to pull SCL low |
| scl_rise | output | 1 | One-cycle strobe on the first cycle of the high phase |
| scl_fall | output | 1 | One-cycle strobe on the first cycle of the low phase |
| cfg_too_fast | output | 1 | Divisor below the slave ratio floor |

## Verification
A slave stretch and a rate-register write can both be in progress within one period. The bench holds the line low past the release and changes BR while the stretch is still running. The stretched period must show the old H on the low side and H + S on the released side. The period after it must show the new H. A write made during the low phase of an unstretched period is checked the same way, along with where `scl_rise` lands inside the stretched high phase.

// File: rtl/scl_rg_pkg.sv
package scl_rg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_WAITH = 2'd2,
    PH_HIGH  = 2'd3
  } scl_phase_e;

  // width of a half-period count: 8 + BR * 4^(max PS), plus a carry bit
  function automatic int half_width(input int br_w, input int ps_w);
    return br_w + 2 * ((1 << ps_w) - 1) + 1;
  endfunction

endpackage

// File: rtl/scl_rg_rst_sync.sv
module scl_rg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/scl_rg_divisor.sv
module scl_rg_divisor #(
  parameter int BR_W            = 8,
  parameter int PS_W            = 2,
  parameter int HALF_W          = 15,
  parameter int SLAVE_RATIO_MIN = 32
) (
  input  logic [BR_W-1:0]   br,
  input  logic [PS_W-1:0]   ps,
  output logic [HALF_W-1:0] half,
  output logic              too_fast
);

  localparam int DIV_W = HALF_W + 1;

  logic [DIV_W-1:0] divisor;

  always_comb begin
    half     = HALF_W'(8) + (HALF_W'(br) << {ps, 1'b0});
    divisor  = {half, 1'b0};
    too_fast = (divisor < DIV_W'(SLAVE_RATIO_MIN));
  end

  // a period can never be shorter than the BR = 0 floor of 16 cycles
  always_comb begin
    assert_div_floor_R8: assert (divisor >= DIV_W'(16));
  end

endmodule

// File: rtl/scl_rg_fsm.sv
module scl_rg_fsm
  import scl_rg_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_in,
  input  logic [HALF_W-1:0] half_in,
  output logic              drive_low,
  output logic              rise,
  output logic              fall
);

  scl_phase_e        phase_q, phase_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              drive_q, drive_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic              start;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    start   = 1'b0;
    if (!en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: start = 1'b1;
        PH_LOW: begin
          if (cnt_q == half_q) phase_d = PH_WAITH;
          else                 cnt_d   = cnt_q + 1'b1;
        end
        PH_WAITH: begin
          // the cycle the line is seen high is the first high cycle
          if (scl_in) begin
            phase_d = PH_HIGH;
            cnt_d   = HALF_W'(2);
            rise_d  = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == half_q) start = 1'b1;
          else                 cnt_d = cnt_q + 1'b1;
        end
        default: phase_d = PH_IDLE;
      endcase
      if (start) begin
        phase_d = PH_LOW;
        cnt_d   = HALF_W'(1);
        half_d  = half_in;
        fall_d  = 1'b1;
      end
    end
    drive_d = (phase_d == PH_LOW);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      drive_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      drive_q <= drive_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign drive_low = drive_q;
  assign rise      = rise_q;
  assign fall      = fall_q;

  assert_release_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drive_q);

  assert_fall_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> drive_q);

  assert_rise_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> ($past(scl_in) && !drive_q));

  assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> ((cnt_q <= half_q) && (cnt_q != '0)));

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_q |-> $stable(half_q));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rg_pkg::*;
#(
  parameter int BR_W            = 8,
  parameter int PS_W            = 2,
  parameter int SLAVE_RATIO_MIN = 32,
  parameter int SYNC_STAGES     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BR_W-1:0] bit_rate,
  input  logic [PS_W-1:0] prescale,
  input  logic            scl_in,
  output logic            scl_drive_low,
  output logic            scl_rise,
  output logic            scl_fall,
  output logic            cfg_too_fast
);

  localparam int HALF_W = half_width(BR_W, PS_W);

  logic              rst_n_sync;
  logic [HALF_W-1:0] half_cycles;

  scl_rg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  scl_rg_divisor #(
    .BR_W            (BR_W),
    .PS_W            (PS_W),
    .HALF_W          (HALF_W),
    .SLAVE_RATIO_MIN (SLAVE_RATIO_MIN)
  ) u_div (
    .br       (bit_rate),
    .ps       (prescale),
    .half     (half_cycles),
    .too_fast (cfg_too_fast)
  );

  scl_rg_fsm #(.HALF_W(HALF_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .en        (en),
    .scl_in    (scl_in),
    .half_in   (half_cycles),
    .drive_low (scl_drive_low),
    .rise      (scl_rise),
    .fall      (scl_fall)
  );

endmodule

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] bit_rate = 8'd0;
  logic [1:0] prescale = 2'd0;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, scl_rise, scl_fall, cfg_too_fast;

  int checks = 0;
  int fails  = 0;
  int r9_bad = 0;

  always #2.5 clk = ~clk;

  // open-drain bus: low if anyone pulls
  assign scl_in = !(scl_drive_low || slave_hold);

  scl_rate_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .bit_rate      (bit_rate),
    .prescale      (prescale),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .cfg_too_fast  (cfg_too_fast)
  );

  always @(negedge clk) if (rst_n && scl_rise && scl_fall) r9_bad++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input int br, input int ps);
    return 8 + br * (1 << (2 * ps));
  endfunction

  task automatic wait_fall();
    do @(negedge clk); while (!scl_fall);
  endtask

  // starts at a negedge with scl_fall high, ends at the next one
  task automatic measure(input int s, input int new_br, input int write_at_hi,
                         output int lo, output int hi, output int rise_at);
    lo = 0; hi = 0; rise_at = 0;
    slave_hold = (s > 0);
    while (scl_drive_low) begin
      lo++;
      if (new_br >= 0 && write_at_hi == 0 && lo == 3) bit_rate = 8'(new_br);
      @(negedge clk);
    end
    while (!scl_fall) begin
      hi++;
      if (scl_rise && rise_at == 0) rise_at = hi;
      if (slave_hold && hi == s + 1) slave_hold = 1'b0;
      if (new_br >= 0 && write_at_hi != 0 && hi == 2) bit_rate = 8'(new_br);
      @(negedge clk);
    end
  endtask

  task automatic stop_gen();
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset drive", int'(scl_drive_low), 0);
    check("R1 reset rise", int'(scl_rise), 0);
    check("R1 reset fall", int'(scl_fall), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 disabled drive", int'(scl_drive_low), 0);
  endtask

  task automatic t_period(input int br, input int ps);
    int lo, hi, ra;
    bit_rate = 8'(br); prescale = 2'(ps);
    @(negedge clk); en = 1'b1;
    wait_fall();
    measure(0, -1, 0, lo, hi, ra);
    check($sformatf("R2 low br=%0d ps=%0d", br, ps), lo, half_of(br, ps));
    check($sformatf("R3 period br=%0d ps=%0d", br, ps), lo + hi, 2 * half_of(br, ps));
    check("R5 rise position", ra, 2);
    stop_gen();
  endtask

  task automatic t_stretch(input int br, input int ps, input int s);
    int lo, hi, ra;
    bit_rate = 8'(br); prescale = 2'(ps);
    @(negedge clk); en = 1'b1;
    wait_fall();
    measure(s, -1, 0, lo, hi, ra);
    check("R4 stretched low", lo, half_of(br, ps));
    check("R4 stretched high", hi, half_of(br, ps) + s);
    check("R5 rise after stretch", ra, s + 2);
    stop_gen();
  endtask

  task automatic t_midwrite();
    int lo, hi, ra;
    bit_rate = 8'd2; prescale = 2'd0;
    @(negedge clk); en = 1'b1;
    wait_fall();
    measure(0, 5, 0, lo, hi, ra);
    check("R6 old low kept", lo, 10);
    check("R6 old high kept", hi, 10);
    measure(0, -1, 0, lo, hi, ra);
    check("R6 new low", lo, 13);
    // write during a stretched released phase
    measure(7, 1, 1, lo, hi, ra);
    check("R6 stretch old low", lo, 13);
    check("R6 stretch old high", hi, 13 + 7);
    measure(0, -1, 0, lo, hi, ra);
    check("R6 stretch new period", lo + hi, 18);
    stop_gen();
  endtask

  task automatic t_disable();
    bit_rate = 8'd4; prescale = 2'd1;
    @(negedge clk); en = 1'b1;
    wait_fall();
    repeat (5) @(negedge clk);
    check("R7 low before drop", int'(scl_drive_low), 1);
    en = 1'b0;
    @(negedge clk);
    check("R7 released after drop", int'(scl_drive_low), 0);
    repeat (40) @(negedge clk);
    check("R1 stays idle", int'(scl_drive_low) + int'(scl_fall) + int'(scl_rise), 0);
    en = 1'b1;
    @(negedge clk);
    check("R7 restart fall", int'(scl_fall), 1);
    check("R7 restart drive", int'(scl_drive_low), 1);
    stop_gen();
  endtask

  task automatic t_cfg();
    bit_rate = 8'd7; prescale = 2'd0; #1;
    check("R8 div 30", int'(cfg_too_fast), 1);
    bit_rate = 8'd8; #1;
    check("R8 div 32", int'(cfg_too_fast), 0);
    bit_rate = 8'd0; prescale = 2'd3; #1;
    check("R8 div 16", int'(cfg_too_fast), 1);
    bit_rate = 8'd1; prescale = 2'd2; #1;
    check("R8 div 48", int'(cfg_too_fast), 0);
  endtask

  initial begin
    t_reset();
    t_period(0, 0);
    t_period(3, 0);
    t_period(2, 1);
    t_period(5, 2);
    t_period(2, 3);
    t_period(20, 3);
    t_stretch(3, 0, 9);
    t_stretch(1, 2, 40);
    t_midwrite();
    t_disable();
    t_cfg();
    check("R9 strobe overlap count", r9_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule